// File: doc/BRIEF.md
# Flash partition configuration command unit

This block is the command front end and partition logic of a four-plane flash device that can read one partition while another partition is busy. It watches a write strobe carrying a command byte and an address. A two-write unlock sequence stores a 16-bit configuration word into a volatile register. The word is taken from the address bus, not from the data bus. Three bits of that word say where the partition boundaries sit between adjacent planes.

From the stored code the block drives two outputs for each plane. One is a 2-bit partition index. The other is a 2-bit status-register select, which points at the lowest plane of the plane's partition, so that merged planes share one status register. A separate identifier-read mode returns the stored word at one fixed word address.

The FSM has three states:
- `ST_ARRAY` is read-array mode.
- `ST_CONFIRM` waits for the second write of the unlock sequence.
- `ST_IDREAD` is identifier-read mode.

The FSM has these transitions:
- Setup: `ST_ARRAY` or `ST_IDREAD` to `ST_CONFIRM` on a write of 60h.
- Identify: `ST_ARRAY` to `ST_IDREAD` on a write of 90h.
- Confirm, abort and mismatch: `ST_CONFIRM` to `ST_ARRAY` on any write.
- Exit: `ST_IDREAD` to `ST_ARRAY` on any write other than 60h or 90h.

Top module: `flash_part_cfg_unit`

## Requirements
- R1: While `rst_n` is low, the FSM is held in read-array mode. The register takes 0400h when `boot_top`=1 and 0100h when `boot_top`=0. Both values put the boundary code in bits 10:8.
- R2: When a write of 60h is followed by a write of 04h at an identical address, `addr[15:0]` is stored at the second write's clock edge. `stat_clr` is high during that second write cycle only, and the unit is then in read-array mode.
- R3: When the 04h write carries a different address than the 60h write, nothing is stored, `stat_clr` stays low and the unit returns to read-array mode.
- R4: When a 60h write is followed by any command other than 04h, the sequence aborts, the register is unchanged and the unit is in read-array mode (`id_mode`=0).
- R5: Boundary code 001 (register bits 10:8; bit 0 = boundary between planes 0 and 1, bit 1 = boundary between planes 1 and 2, bit 2 = boundary between planes 2 and 3) gives partition indices 0,1,1,1 and status selects 0,1,1,1 for planes 0..3.
- R6: Code 101 gives partition indices 0,1,1,2 and status selects 0,1,1,3.
- R7: Code 111 gives partition indices 0,1,2,3 and status selects 0,1,2,3.
- R8: Code 100 (the top-boot default) gives partition indices 0,0,0,1 and status selects 0,0,0,3.
- R9: Codes 000, 010, 011 and 110 are mapped as the boot-type default: as 100 when `boot_top`=1 and as 001 when `boot_top`=0. The stored word still reads back unchanged.
- R10: After a 90h write, `id_mode` is 1. At `addr`=000006h, `rd_data` returns the register. At any other address in that mode, and at any address in read-array mode, `rd_data` is 0.
- R11: In identifier mode, a write of 60h starts the unlock sequence, a write of 90h stays in the mode, and any other write returns to read-array mode.
- R12: In read-array mode, writes other than 60h and 90h change neither the state nor the register.

Outputs are packed with plane p in bits [2p+1:2p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_top | input | 1 | Boot-type strap: 1 = top-parameter, 0 = bottom-parameter |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| cmd_data | input | 8 | Command byte |
| addr | input | 21 | Word address; its low 16 bits carry the configuration word |
| rd_data | output | 16 | Identifier-read data |
| id_mode | output | 1 | High in identifier-read mode |
| stat_clr | output | 1 | Clear-all-status pulse during an accepted confirm write |
| plane_part | output | 8 | Partition index per plane |
| stat_sel | output | 8 | Shared status-register select per plane |

## Verification
All eight boundary codes are driven through the full unlock sequence under the top-boot strap. Each code's two maps and its identifier readback are compared against a table. This separates the four defined layouts from one another and from the undefined codes, which must collapse onto the default.

Directed sequences follow:
- a mismatched confirm address;
- a wrong second command;
- stray commands in read-array mode;
- entry into and exit from identifier mode.

These cases tell a refused sequence apart from an accepted one, because the map and the readback must stay as they were. Resets under both strap values separate the two defaults. A bottom-strap undefined code shows that the fallback follows the strap.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int NUM_PLANES = 4;
    localparam int IDX_W      = 2;
    localparam int CFG_W      = 16;
    localparam int CODE_W     = NUM_PLANES - 1;
    localparam int CODE_LSB   = 8;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'h04;
    localparam logic [7:0] CMD_IDENT   = 8'h90;

    localparam logic [CODE_W-1:0] CODE_TOP_DFLT = 3'b100;
    localparam logic [CODE_W-1:0] CODE_BOT_DFLT = 3'b001;

    typedef enum logic [1:0] {
        ST_ARRAY   = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_IDREAD  = 2'd2
    } fpc_state_t;
endpackage

// File: rtl/fpc_cmd_fsm.sv
module fpc_cmd_fsm
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        cmd_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              load_o,
    output logic              id_mode_o
);
    fpc_state_t        state_q, state_d;
    logic [ADDR_W-1:0] setup_addr_q;
    logic              take_setup;

    // A setup write is legal from read-array or identifier mode.
    assign take_setup = wr_en && (cmd_data == CMD_SETUP) && (state_q != ST_CONFIRM);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARRAY: begin
                if (wr_en) begin
                    if (cmd_data == CMD_SETUP)      state_d = ST_CONFIRM;
                    else if (cmd_data == CMD_IDENT) state_d = ST_IDREAD;
                end
            end
            ST_CONFIRM: begin
                // Confirm, mismatch and abort all land in read-array mode.
                if (wr_en) state_d = ST_ARRAY;
            end
            ST_IDREAD: begin
                if (wr_en) begin
                    if (cmd_data == CMD_SETUP)      state_d = ST_CONFIRM;
                    else if (cmd_data == CMD_IDENT) state_d = ST_IDREAD;
                    else                            state_d = ST_ARRAY;
                end
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_ARRAY;
            setup_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (take_setup) setup_addr_q <= addr;
        end
    end

    // Outputs
    always_comb begin
        load_o    = (state_q == ST_CONFIRM) && wr_en &&
                    (cmd_data == CMD_CONFIRM) && (addr == setup_addr_q);
        id_mode_o = (state_q == ST_IDREAD);
    end
endmodule

// File: rtl/fpc_cfg_reg.sv
module fpc_cfg_reg
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_top,
    input  logic             load,
    input  logic [CFG_W-1:0] din,
    output logic [CFG_W-1:0] q
);
    logic [CFG_W-1:0] dflt;

    always_comb begin
        dflt = '0;
        dflt[CODE_LSB +: CODE_W] = boot_top ? CODE_TOP_DFLT : CODE_BOT_DFLT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= dflt;
        else if (load) q <= din;
    end
endmodule

// File: rtl/fpc_part_map.sv
module fpc_part_map
    import fpc_pkg::*;
(
    input  logic [CODE_W-1:0]           code,
    input  logic                        boot_top,
    output logic [NUM_PLANES*IDX_W-1:0] plane_part_o,
    output logic [NUM_PLANES*IDX_W-1:0] stat_sel_o
);
    logic [CODE_W-1:0] eff;
    logic              valid;
    logic [IDX_W-1:0]  part_a [NUM_PLANES];
    logic [IDX_W-1:0]  sel_a  [NUM_PLANES];

    always_comb begin
        unique case (code)
            3'b001, 3'b100, 3'b101, 3'b111: valid = 1'b1;
            default:                        valid = 1'b0;
        endcase
        eff = valid ? code : (boot_top ? CODE_TOP_DFLT : CODE_BOT_DFLT);
    end

    // Each boundary bit opens a new partition at the plane above it.
    always_comb begin
        part_a[0] = '0;
        sel_a[0]  = '0;
        for (int p = 1; p < NUM_PLANES; p++) begin
            part_a[p] = part_a[p-1] + IDX_W'(eff[p-1]);
            sel_a[p]  = eff[p-1] ? IDX_W'(p) : sel_a[p-1];
        end
    end

    for (genvar g = 0; g < NUM_PLANES; g++) begin : g_pack
        assign plane_part_o[g*IDX_W +: IDX_W] = part_a[g];
        assign stat_sel_o[g*IDX_W +: IDX_W]   = sel_a[g];
    end
endmodule

// File: rtl/flash_part_cfg_unit.sv
module flash_part_cfg_unit
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter logic [ADDR_W-1:0] ID_CFG_ADDR = 21'h000006
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        boot_top,
    input  logic                        wr_en,
    input  logic [7:0]                  cmd_data,
    input  logic [ADDR_W-1:0]           addr,
    output logic [CFG_W-1:0]            rd_data,
    output logic                        id_mode,
    output logic                        stat_clr,
    output logic [NUM_PLANES*IDX_W-1:0] plane_part,
    output logic [NUM_PLANES*IDX_W-1:0] stat_sel
);
    logic             load;
    logic [CFG_W-1:0] cfg_q;

    fpc_cmd_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .cmd_data  (cmd_data),
        .addr      (addr),
        .load_o    (load),
        .id_mode_o (id_mode)
    );

    fpc_cfg_reg reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_top (boot_top),
        .load     (load),
        .din      (addr[CFG_W-1:0]),
        .q        (cfg_q)
    );

    fpc_part_map map_i (
        .code         (cfg_q[CODE_LSB +: CODE_W]),
        .boot_top     (boot_top),
        .plane_part_o (plane_part),
        .stat_sel_o   (stat_sel)
    );

    assign stat_clr = load;
    assign rd_data  = (id_mode && (addr == ID_CFG_ADDR)) ? cfg_q : '0;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
    import fpc_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic                        id_mode,
    input logic                        stat_clr,
    input logic [CFG_W-1:0]            rd_data,
    input logic [CFG_W-1:0]            cfg_q,
    input logic [NUM_PLANES*IDX_W-1:0] plane_part
);
    // R2 R3 R4 R12: the register moves only on an accepted confirm
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> $stable(cfg_q));

    // R2: the status clear rides on a write cycle
    p_clr_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> wr_en);

    // R2: an accepted sequence ends in read-array mode
    p_back_to_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !id_mode);

    // R10: outside identifier mode the read port is quiet
    p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> (rd_data == '0));

    // R5: plane 0 always sits in partition 0
    p_plane0_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        plane_part[IDX_W-1:0] == '0);

    // R9: partition indices climb by at most one per plane
    for (genvar g = 1; g < NUM_PLANES; g++) begin : g_step
        p_part_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (plane_part[g*IDX_W +: IDX_W] - plane_part[(g-1)*IDX_W +: IDX_W]) <= 1);
    end
endmodule

bind flash_part_cfg_unit fpc_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .id_mode    (id_mode),
    .stat_clr   (stat_clr),
    .rd_data    (rd_data),
    .cfg_q      (cfg_q),
    .plane_part (plane_part)
);

// File: tb/flash_part_cfg_unit_tb_top.sv
module flash_part_cfg_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_top = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic [20:0] addr = '0;
    logic [15:0] rd_data;
    logic        id_mode;
    logic        stat_clr;
    logic [7:0]  plane_part;
    logic [7:0]  stat_sel;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_part_cfg_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_top   (boot_top),
        .wr_en      (wr_en),
        .cmd_data   (cmd_data),
        .addr       (addr),
        .rd_data    (rd_data),
        .id_mode    (id_mode),
        .stat_clr   (stat_clr),
        .plane_part (plane_part),
        .stat_sel   (stat_sel)
    );

    // Indexed by boundary code under boot_top=1: {plane_part, stat_sel}
    localparam logic [15:0] MAP_TOP [8] = '{
        16'h40C0,  // 000 undefined -> default 100 (R9)
        16'h5454,  // 001 (R5)
        16'h40C0,  // 010 undefined (R9)
        16'h40C0,  // 011 undefined (R9)
        16'h40C0,  // 100 (R8)
        16'h94D4,  // 101 (R6)
        16'h40C0,  // 110 undefined (R9)
        16'hE4E4   // 111 (R7)
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] c, input logic [20:0] a,
                         input logic exp_clr, input string tag);
        @(negedge clk);
        wr_en = 1'b1; cmd_data = c; addr = a;
        #1;
        chk(tag, {15'd0, stat_clr}, {15'd0, exp_clr});
        @(negedge clk);
        wr_en = 1'b0; cmd_data = 8'h00; addr = '0;
    endtask

    task automatic rd_at(input logic [20:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic do_reset(input logic top);
        @(negedge clk);
        rst_n = 1'b0; boot_top = top;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_cfg(input logic [20:0] a, input string tag);
        do_wr(8'h60, a, 1'b0, tag);
        do_wr(8'h04, a, 1'b1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [20:0] a;
        // R1: reset state with top boot strap
        do_reset(1'b1);
        #1;
        chk("R1 id_mode after reset", {15'd0, id_mode}, 16'd0);
        chk("R1 stat_clr after reset", {15'd0, stat_clr}, 16'd0);
        chk("R1 top default map", {plane_part, stat_sel}, 16'h40C0);
        do_wr(8'h90, '0, 1'b0, "R10 enter id");
        rd_at(21'h6, 16'h0400, "R1 top default readback");
        do_wr(8'hFF, '0, 1'b0, "R11 exit id");

        // Table walk over every boundary code (R2 R5..R9)
        for (int i = 0; i < 8; i++) begin
            a = {5'h11, 5'b10101, 3'(i), 8'h3C};
            set_cfg(a, "R2 confirm clr");
            #1;
            chk("R2 back to array", {15'd0, id_mode}, 16'd0);
            chk("R5-R9 plane_part/stat_sel table", {plane_part, stat_sel}, MAP_TOP[i]);
            do_wr(8'h90, '0, 1'b0, "R10 enter id");
            rd_at(21'h6, a[15:0], "R9 stored word readback");
            rd_at(21'h5, 16'h0000, "R10 other id address");
            do_wr(8'hFF, '0, 1'b0, "R11 leave id");
            #1;
            chk("R11 id_mode cleared", {15'd0, id_mode}, 16'd0);
        end

        // Set known code 111 for the directed cases
        a = 21'h000755;
        set_cfg(a, "R2 set 111");

        // R3: confirm address differs
        do_wr(8'h60, 21'h000155, 1'b0, "R3 setup");
        do_wr(8'h04, 21'h000154, 1'b0, "R3 mismatch no clr");
        #1;
        chk("R3 map unchanged", {plane_part, stat_sel}, 16'hE4E4);
        chk("R3 read-array", {15'd0, id_mode}, 16'd0);

        // R4: wrong second command (90h) aborts to read-array
        do_wr(8'h60, 21'h000155, 1'b0, "R4 setup");
        do_wr(8'h90, 21'h000155, 1'b0, "R4 abort no clr");
        #1;
        chk("R4 id_mode low after abort", {15'd0, id_mode}, 16'd0);
        chk("R4 map unchanged", {plane_part, stat_sel}, 16'hE4E4);
        rd_at(21'h6, 16'h0000, "R10 array mode read zero");

        // R12: stray commands in read-array mode
        do_wr(8'h04, 21'h000155, 1'b0, "R12 lone confirm");
        do_wr(8'h20, 21'h000155, 1'b0, "R12 other cmd");
        #1;
        chk("R12 map unchanged", {plane_part, stat_sel}, 16'hE4E4);
        chk("R12 still array", {15'd0, id_mode}, 16'd0);
        do_wr(8'h90, '0, 1'b0, "R12 id entry");
        rd_at(21'h6, 16'h0755, "R12 register unchanged");

        // R11: 90h keeps identifier mode, 60h from it starts a sequence
        do_wr(8'h90, '0, 1'b0, "R11 repeat id");
        #1;
        chk("R11 stays id", {15'd0, id_mode}, 16'd1);
        set_cfg(21'h000155, "R11 sequence from id");
        #1;
        chk("R11 loaded from id mode", {plane_part, stat_sel}, 16'h5454);
        chk("R11 array after load", {15'd0, id_mode}, 16'd0);

        // R1/R9: bottom boot strap
        do_reset(1'b0);
        #1;
        chk("R1 bottom default map", {plane_part, stat_sel}, 16'h5454);
        do_wr(8'h90, '0, 1'b0, "R10 enter id");
        rd_at(21'h6, 16'h0100, "R1 bottom default readback");
        set_cfg(21'h000300, "R9 undefined under bottom");
        #1;
        chk("R9 bottom fallback map", {plane_part, stat_sel}, 16'h5454);
        set_cfg(21'h000400, "R8 code 100 bottom strap");
        #1;
        chk("R8 code 100 explicit", {plane_part, stat_sel}, 16'h40C0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule